// File: doc/BRIEF.md
# Modem Status Flag Register

This block keeps the event flags that a four-level FSK modem controller reports to its host microcontroller. Strobes from the receive and transmit datapaths and from the command decoder set or load a small group of flags: a de-interleave overflow flag, a CRC error flag, a special-symbol-ready flag, and a two-bit field that holds the value of the last special symbol received. The flags are packed into one status word that the host can read at any time.

Each flag follows its own clear rule. The overflow flag and the symbol-ready flag clear after a host read. The CRC error flag stays through reads. A reset command clears every flag, and so does any change of the transmit/receive or power-save mode inputs. While the modem transmits, the receive-only fields are held at zero. An overflow also raises an interrupt request, which stays high until the host reads the status word.

Top module: `modem_status_reg`

## Requirements
- R1: One clock edge with `rst` high sets `status_word` to all zeros and `irq` to 0. Bits 7:5 of `status_word` are always 0.
- R2: In receive mode (`tx_mode`=0), a pulse on `late_rx_task` sets bit 4 (overflow) and `irq` at the next clock edge.
- R3: A read (`rd_stb` high for one cycle) returns the flags as they were before it. At the edge that ends the read cycle, bit 4 and bit 2 clear, unless a new event sets them in that same cycle.
- R4: When a set event and a read happen in the same cycle, the set wins and the flag is 1 after the edge. This holds for bit 4, bit 2 and `irq`.
- R5: In receive mode, a `crc_done` pulse loads bit 3 with `crc_bad` (1 means CRC failure, 0 means good). A read does not change bit 3.
- R6: Bit 2 (symbol ready) sets on `sym_rx` in receive mode or on `sym_tx` in transmit mode. `sym_tx` has no effect in receive mode, and `sym_rx` has no effect in transmit mode.
- R7: In receive mode, a `sym_rx` pulse loads bits 1:0 with `sym_val`. A read does not change bits 1:0.
- R8: A `reset_task` pulse clears bits 4:0 and `irq` at the next edge. It wins over any set or load event in the same cycle.
- R9: When `tx_mode` or `psave` differs from its value in the previous cycle, bits 4:0 and `irq` clear at that edge. The clear wins over any event in the same cycle.
- R10: In transmit mode, bits 4, 3 and 1:0 and `irq` are held at 0. `late_rx_task`, `crc_done` and `sym_rx` are ignored.
- R11: `irq` stays high until a read, a reset task or a mode change clears it. A read clears `irq` at the edge that ends the read cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode |
| psave | input | 1 | Power-save mode bit |
| reset_task | input | 1 | Reset command strobe from the command decoder |
| late_rx_task | input | 1 | Strobe: a receive-block command arrived too late for continuous reception |
| crc_done | input | 1 | Strobe: a sync or block receive task finished |
| crc_bad | input | 1 | CRC result that goes with `crc_done` (1 = error) |
| sym_rx | input | 1 | Strobe: a special symbol was received |
| sym_tx | input | 1 | Strobe: a special symbol was sent |
| sym_val | input | 2 | Value of the received special symbol, valid with `sym_rx` |
| rd_stb | input | 1 | Host read strobe for the status word |
| status_word | output | STAT_W (8) | Status word: bit 4 overflow, bit 3 CRC error, bit 2 symbol ready, bits 1:0 symbol value |
| irq | output | 1 | Interrupt request |

## Verification
The cases hardest to reach from the ports are collisions within one cycle: a read that arrives together with a new overflow or symbol event, and a reset command or mode toggle that arrives together with a set event. Each of these decides which rule has priority. The bench first puts a flag into a known state. It then drives both strobes in the same cycle, between clock edges, and checks the result after that single edge. It also checks the value seen during the read cycle, to confirm that the read returns the flags from before the clear. Transmit mode is covered by sending receive-only events while `tx_mode` is high and confirming that no field moves.

// File: rtl/modem_status_pkg.sv
package modem_status_pkg;

    localparam int SYM_W    = 2;
    localparam int FLAG_W   = SYM_W + 3;
    localparam int OVF_POS  = 4;
    localparam int CRC_POS  = 3;
    localparam int RDY_POS  = 2;

    typedef struct packed {
        logic             ovf;
        logic             crc_err;
        logic             sym_rdy;
        logic [SYM_W-1:0] sym_val;
    } stat_flags_t;

    typedef struct packed {
        logic tx;
        logic psave;
    } mode_bits_t;

    function automatic logic [FLAG_W-1:0] pack_flags(stat_flags_t f);
        logic [FLAG_W-1:0] w;
        w = '0;
        w[OVF_POS]     = f.ovf;
        w[CRC_POS]     = f.crc_err;
        w[RDY_POS]     = f.sym_rdy;
        w[SYM_W-1:0]   = f.sym_val;
        return w;
    endfunction

endpackage

// File: rtl/mode_watch.sv
module mode_watch
    import modem_status_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_mode,
    input  logic psave,
    output logic mode_change
);
    mode_bits_t mode_now;
    mode_bits_t mode_q;

    always_comb begin
        mode_now.tx    = tx_mode;
        mode_now.psave = psave;
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_now;
    end

    assign mode_change = !rst && (mode_now != mode_q);

    // R9: a toggle of either mode input is reported as a change
    a_r9_toggle_seen: assert property (@(posedge clk) disable iff (rst)
        (tx_mode != $past(tx_mode)) |-> mode_change);

endmodule

// File: rtl/flag_cell.sv
module flag_cell #(
    parameter bit RD_CLEAR = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic evt_val,
    input  logic rd_clr,
    input  logic hard_clr,
    input  logic force_zero,
    output logic flag_q
);
    logic flag_d;

    generate
        if (RD_CLEAR) begin : g_rd_clear
            always_comb begin
                if (hard_clr || force_zero) flag_d = 1'b0;
                else if (evt)               flag_d = evt_val;
                else if (rd_clr)            flag_d = 1'b0;
                else                        flag_d = flag_q;
            end

            // R3: a read with no competing event clears the flag
            a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
                (rd_clr && !evt) |=> !flag_q);
            // R4: a set that meets a read still leaves the flag set
            a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
                (rd_clr && evt && evt_val && !hard_clr && !force_zero) |=> flag_q);
        end else begin : g_rd_keep
            always_comb begin
                if (hard_clr || force_zero) flag_d = 1'b0;
                else if (evt)               flag_d = evt_val;
                else                        flag_d = flag_q;
            end

            // R5: a read alone leaves the flag unchanged
            a_r5_read_keeps: assert property (@(posedge clk) disable iff (rst)
                (rd_clr && !evt && !hard_clr && !force_zero) |=> (flag_q == $past(flag_q)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    // R8 / R9: a hard clear always empties the flag
    a_r8_hard_clear: assert property (@(posedge clk) disable iff (rst)
        hard_clr |=> !flag_q);

endmodule

// File: rtl/sym_value_reg.sv
module sym_value_reg #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [WIDTH-1:0] val_in,
    input  logic             hard_clr,
    input  logic             force_zero,
    output logic [WIDTH-1:0] val_q
);
    always_ff @(posedge clk) begin
        if (rst || hard_clr || force_zero) val_q <= '0;
        else if (capture)                  val_q <= val_in;
    end

    // R7: a captured symbol value shows after one edge
    a_r7_capture: assert property (@(posedge clk) disable iff (rst)
        (capture && !hard_clr && !force_zero) |=> (val_q == $past(val_in)));

endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import modem_status_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_mode,
    input  logic              psave,
    input  logic              reset_task,
    input  logic              late_rx_task,
    input  logic              crc_done,
    input  logic              crc_bad,
    input  logic              sym_rx,
    input  logic              sym_tx,
    input  logic [SYM_W-1:0]  sym_val,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] status_word,
    output logic              irq
);
    localparam int PAD_W = STAT_W - FLAG_W;

    logic        mode_change;
    logic        hard_clr;
    logic        rx_mode;
    logic        ovf_evt;
    logic        rdy_evt;
    stat_flags_t flags;

    mode_watch u_mode (
        .clk         (clk),
        .rst         (rst),
        .tx_mode     (tx_mode),
        .psave       (psave),
        .mode_change (mode_change)
    );

    assign hard_clr = reset_task || mode_change;
    assign rx_mode  = !tx_mode;
    assign ovf_evt  = late_rx_task && rx_mode;
    assign rdy_evt  = (sym_rx && rx_mode) || (sym_tx && tx_mode);

    flag_cell #(.RD_CLEAR(1'b1)) u_ovf (
        .clk(clk), .rst(rst), .evt(ovf_evt), .evt_val(1'b1), .rd_clr(rd_stb),
        .hard_clr(hard_clr), .force_zero(tx_mode), .flag_q(flags.ovf)
    );

    flag_cell #(.RD_CLEAR(1'b0)) u_crc (
        .clk(clk), .rst(rst), .evt(crc_done), .evt_val(crc_bad), .rd_clr(rd_stb),
        .hard_clr(hard_clr), .force_zero(tx_mode), .flag_q(flags.crc_err)
    );

    flag_cell #(.RD_CLEAR(1'b1)) u_rdy (
        .clk(clk), .rst(rst), .evt(rdy_evt), .evt_val(1'b1), .rd_clr(rd_stb),
        .hard_clr(hard_clr), .force_zero(1'b0), .flag_q(flags.sym_rdy)
    );

    flag_cell #(.RD_CLEAR(1'b1)) u_irq (
        .clk(clk), .rst(rst), .evt(ovf_evt), .evt_val(1'b1), .rd_clr(rd_stb),
        .hard_clr(hard_clr), .force_zero(tx_mode), .flag_q(irq)
    );

    sym_value_reg #(.WIDTH(SYM_W)) u_sval (
        .clk(clk), .rst(rst), .capture(sym_rx && rx_mode), .val_in(sym_val),
        .hard_clr(hard_clr), .force_zero(tx_mode), .val_q(flags.sym_val)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign status_word = {{PAD_W{1'b0}}, pack_flags(flags)};
        end else begin : g_nopad
            assign status_word = pack_flags(flags);
        end
    endgenerate

    // R2: the overflow flag never rises without the interrupt
    a_r2_irq_with_ovf: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[OVF_POS]) |-> irq);
    // R10: receive-only fields stay zero after a transmit-mode edge
    a_r10_tx_zero: assert property (@(posedge clk) disable iff (rst)
        tx_mode |=> (status_word[OVF_POS] == 1'b0 && status_word[CRC_POS] == 1'b0
                     && status_word[SYM_W-1:0] == '0 && !irq));
    // R11: the interrupt is held while nothing may clear it
    a_r11_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (irq && !rd_stb && !reset_task && !mode_change && !tx_mode) |=> irq);
    // R9: a mode change empties every field
    a_r9_mode_clear: assert property (@(posedge clk) disable iff (rst)
        mode_change |=> (status_word[FLAG_W-1:0] == '0 && !irq));

endmodule

// File: tb/test_modem_status_reg.sv
`timescale 1ns/1ps
module test_modem_status_reg;
    logic       clk = 1'b0;
    logic       rst;
    logic       tx_mode, psave, reset_task, late_rx_task;
    logic       crc_done, crc_bad, sym_rx, sym_tx, rd_stb;
    logic [1:0] sym_val;
    logic [7:0] status_word;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    modem_status_reg i_modem_status_reg (
        .clk(clk), .rst(rst), .tx_mode(tx_mode), .psave(psave),
        .reset_task(reset_task), .late_rx_task(late_rx_task),
        .crc_done(crc_done), .crc_bad(crc_bad), .sym_rx(sym_rx),
        .sym_tx(sym_tx), .sym_val(sym_val), .rd_stb(rd_stb),
        .status_word(status_word), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic quiet();
        reset_task = 0; late_rx_task = 0; crc_done = 0; crc_bad = 0;
        sym_rx = 0; sym_tx = 0; sym_val = 0; rd_stb = 0;
    endtask

    task automatic do_read();
        rd_stb = 1; tick(); rd_stb = 0;
    endtask

    task automatic t_reset();
        rst = 1; tx_mode = 0; psave = 0; quiet();
        tick(); tick(); rst = 0; tick();
        check("R1 status after reset", status_word, 8'h00);
        check("R1 irq after reset", irq, 0);
    endtask

    task automatic t_overflow();
        late_rx_task = 1; tick(); late_rx_task = 0;
        check("R2 overflow bit", status_word, 8'h10);
        check("R2 irq", irq, 1);
        tick();
        check("R11 irq held", irq, 1);
        rd_stb = 1; #1;
        check("R3 read returns pre-clear value", status_word, 8'h10);
        tick(); rd_stb = 0;
        check("R3 overflow cleared by read", status_word, 8'h00);
        check("R11 irq cleared by read", irq, 0);
    endtask

    task automatic t_set_wins();
        late_rx_task = 1; sym_rx = 1; sym_val = 2'b01; tick();
        late_rx_task = 1; sym_rx = 1; sym_val = 2'b11; rd_stb = 1; tick(); quiet();
        check("R4 set beats read", status_word, 8'h17);
        check("R4 irq set beats read", irq, 1);
        do_read();
        check("R3 bits 4,2 clear, value kept", status_word, 8'h03);
    endtask

    task automatic t_crc();
        crc_done = 1; crc_bad = 1; tick(); crc_done = 0; crc_bad = 0;
        check("R5 crc error loaded", status_word[3], 1);
        do_read(); do_read();
        check("R5 crc error survives reads", status_word[3], 1);
        crc_done = 1; crc_bad = 0; tick(); crc_done = 0;
        check("R5 crc good loaded", status_word[3], 0);
    endtask

    task automatic t_symbol();
        sym_rx = 1; sym_val = 2'b10; tick(); sym_rx = 0; sym_val = 2'b01;
        check("R6 R7 symbol ready and value", status_word[2:0], 3'b110);
        do_read();
        check("R7 value kept after read, R6 ready cleared", status_word[2:0], 3'b010);
        sym_tx = 1; tick(); sym_tx = 0;
        check("R6 sym_tx ignored in receive mode", status_word[2:0], 3'b010);
    endtask

    task automatic t_reset_task();
        late_rx_task = 1; crc_done = 1; crc_bad = 1; sym_rx = 1; sym_val = 2'b11; tick(); quiet();
        check("R8 setup", status_word, 8'h1F);
        reset_task = 1; late_rx_task = 1; sym_rx = 1; sym_val = 2'b01; crc_done = 1; crc_bad = 1;
        tick(); quiet();
        check("R8 reset task clears, beats events", status_word, 8'h00);
        check("R8 irq cleared", irq, 0);
    endtask

    task automatic t_mode_change();
        late_rx_task = 1; crc_done = 1; crc_bad = 1; tick(); quiet();
        psave = 1; late_rx_task = 1; tick(); quiet();
        check("R9 psave toggle clears", status_word, 8'h00);
        check("R9 psave toggle clears irq", irq, 0);
        crc_done = 1; crc_bad = 1; tick(); quiet();
        check("R5 crc loads with psave steady", status_word, 8'h08);
        psave = 0; tick();
        check("R9 psave release clears", status_word, 8'h00);
    endtask

    task automatic t_tx();
        late_rx_task = 1; sym_rx = 1; sym_val = 2'b10; tick(); quiet();
        tx_mode = 1; tick();
        check("R9 tx toggle clears", status_word, 8'h00);
        late_rx_task = 1; crc_done = 1; crc_bad = 1; sym_rx = 1; sym_val = 2'b11; tick(); quiet();
        check("R10 receive events ignored in tx", status_word, 8'h00);
        check("R10 irq held low in tx", irq, 0);
        sym_tx = 1; tick(); sym_tx = 0;
        check("R6 symbol sent sets ready in tx", status_word, 8'h04);
        do_read();
        check("R3 ready cleared by read in tx", status_word, 8'h00);
        tx_mode = 0; tick();
        check("R9 back to receive", status_word, 8'h00);
    endtask

    initial begin
        t_reset();
        t_overflow();
        t_set_wins();
        t_crc();
        t_symbol();
        t_reset_task();
        t_mode_change();
        t_tx();
        rst = 1; tick(); rst = 0; tick();
        check("R1 reset clears again", {irq, status_word}, 9'h000);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule